// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Break-Before-Make Switching

This block controls a parallel group of general-purpose pins through a small register bus. Software sets a direction mask, an output value and a pull-up mask, flips output bits by writing ones to the pin input address, and reads back the pad levels after synchronization. Each pin drives three signals toward its pad model: an output enable, an output level and a pull-up enable.

A single port-wide control bit turns on break-before-make switching. In that mode, any pin whose direction goes from input to output has its driver held off for one clock before it starts driving. A pin going from output to input is released at once. Reset forces every output enable low without waiting for a clock edge, and then clears all control state.

Top module: `gpio_bbm_port`

## Requirements
- R1: `pad_pu` equals the pull-up register (address 3) bit for bit, whatever the direction bits hold.
- R2: A pin whose direction bit (address 1) is 0 has its `pad_oe` bit at 0, whatever its output data bit holds.
- R3: A pin whose direction bit is 1 and is not in a break-before-make gap has `pad_oe` at 1, and `pad_out` carries its output data bit (address 2).
- R4: A write to address 0 inverts each output data bit whose write bit is 1, whatever the direction, and leaves bits written 0 unchanged.
- R5: With break-before-make on, a pin whose direction goes from 0 to 1 has `pad_oe` low in the first cycle after the write and high in the second.
- R6: A pin whose direction goes from 1 to 0 has `pad_oe` low in the first cycle after the write, with break-before-make on or off.
- R7: With break-before-make off, a 0-to-1 direction change raises `pad_oe` in the first cycle after the write, the same cycle the register shows the new value.
- R8: Break-before-make is bit 0 of the control register (address 4) and applies to the whole port; in one write, only pins going from 0 to 1 get the gap, and pins already at 1 keep driving.
- R9: While `rst` is high, `pad_oe` is all zeros without a clock edge; after a clocked reset the direction, output, pull-up and control registers read 0.
- R10: Reading address 0 returns `pad_in` through a two-stage synchronizer and a registered read port: a pad change made after edge N is seen on `rd_data` after edge N+3 and not after edge N+2.
- R11: `rd_data` shows the register selected by `addr` at the previous edge: direction at 1, output data at 2, pull-up at 3, control at 4 with break-before-make in bit 0 and other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; also forces output enables low at once |
| wr_en | input | 1 | Write strobe for the register addressed by `addr` |
| addr | input | 3 | Register address: 0 pin/toggle, 1 direction, 2 output, 3 pull-up, 4 control |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the address seen at the previous edge |
| pad_in | input | 8 | Pad input levels, asynchronous to `clk` |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The assertions assume one register access per cycle and addresses in the 0 to 4 range, so that a direction write and a toggle write never land in the same cycle. The gap properties also assume reset stays low for the cycle after the write they watch. The stimulus drives one write at a time, only to mapped addresses, and raises reset only after the break-before-make cases have settled. Pad inputs change only in quiet windows long enough to cover the synchronizer delay.

// File: rtl/gpio_bbm_pkg.sv
package gpio_bbm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PIN  = 3'd0,
    A_DIR  = 3'd1,
    A_OUT  = 3'd2,
    A_PULL = 3'd3,
    A_CTRL = 3'd4
  } gpio_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bbm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      pu_q,
  output logic              bbm_q,
  output logic              wr_dir
);
  logic wr_pin, wr_out, wr_pull, wr_ctrl;

  always_comb begin
    wr_pin  = wr_en && (addr == A_PIN);
    wr_dir  = wr_en && (addr == A_DIR);
    wr_out  = wr_en && (addr == A_OUT);
    wr_pull = wr_en && (addr == A_PULL);
    wr_ctrl = wr_en && (addr == A_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      pu_q  <= '0;
      bbm_q <= 1'b0;
    end else begin
      if (wr_dir)  dir_q <= wdata;
      if (wr_pull) pu_q  <= wdata;
      if (wr_ctrl) bbm_q <= wdata[0];
      if (wr_out)       out_q <= wdata;
      else if (wr_pin)  out_q <= out_q ^ wdata;
    end
  end

  // R4
  toggle_inverts_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pin |=> (out_q == ($past(out_q) ^ $past(wdata))));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && out_q == '0 && pu_q == '0 && !bbm_q));
endmodule

// File: rtl/gpio_bbm_gate.sv
module gpio_bbm_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bbm,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] oe
);
  logic [W-1:0] gap_q;
  logic [W-1:0] rising;

  always_comb rising = wdata & ~dir_q;

  always_ff @(posedge clk) begin
    if (rst) gap_q <= '0;
    else     gap_q <= (bbm && wr_dir) ? rising : '0;
  end

  always_comb oe = dir_q & ~gap_q;

  // R5
  bbm_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (bbm && wr_dir) |=> ((oe & $past(rising)) == '0));

  // R5
  bbm_gap_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (bbm && wr_dir) |=> ##1 ((oe & $past(rising, 2) & dir_q) == ($past(rising, 2) & dir_q)));

  // R6
  release_now_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> ((oe & ~$past(wdata)) == '0));

  // R7
  no_gap_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!bbm && wr_dir) |=> (oe == $past(wdata)));

  // R8
  steady_pins_drive_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> ((oe & $past(wdata & dir_q)) == $past(wdata & dir_q)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bbm_port.sv
module gpio_bbm_port
  import gpio_bbm_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu
);
  logic [W-1:0] dir_q, out_q, pu_q, oe_int, pin_sync;
  logic         bbm_q, wr_dir;

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_q(dir_q), .out_q(out_q), .pu_q(pu_q), .bbm_q(bbm_q), .wr_dir(wr_dir)
  );

  gpio_bbm_gate #(.W(W)) u_gate (
    .clk(clk), .rst(rst), .bbm(bbm_q), .wr_dir(wr_dir), .wdata(wdata),
    .dir_q(dir_q), .oe(oe_int)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (addr)
        A_PIN:   rd_data <= pin_sync;
        A_DIR:   rd_data <= dir_q;
        A_OUT:   rd_data <= out_q;
        A_PULL:  rd_data <= pu_q;
        A_CTRL:  rd_data <= {{(W-1){1'b0}}, bbm_q};
        default: rd_data <= '0;
      endcase
    end
  end

  // Reset releases every driver without waiting for a clock edge.
  always_comb begin
    pad_oe  = oe_int & {W{~rst}};
    pad_out = out_q;
    pad_pu  = pu_q;
  end

  // R2
  input_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~dir_q) == '0);

  // R11
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CTRL) |=> (rd_data[W-1:1] == '0));
endmodule

// File: tb/test_gpio_bbm_port.sv
`timescale 1ns/1ps
module test_gpio_bbm_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] rd_data, pad_oe, pad_out, pad_pu;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int         at;
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_bbm_port i_gpio_bbm_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // sel: 0 pad_oe, 1 pad_out, 2 pad_pu, 3 rd_data
  task automatic expect_at(int dly, int sel, logic [7:0] v, string req);
    item_t it;
    it.at = cyc + dly; it.sel = sel; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: pops items due in this cycle at the falling edge.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic [7:0] act;
        case (sb[i].sel)
          0: act = pad_oe;
          1: act = pad_out;
          2: act = pad_pu;
          default: act = rd_data;
        endcase
        n_chk++;
        if (act !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h cyc=%0d",
                   sb[i].req, sb[i].sel, act, sb[i].exp, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Returns in the first cycle that shows the written value.
  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [7:0] v, string req);
    addr = a;
    step();
    expect_at(0, 3, v, req);
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    // R9 reset state
    expect_at(0, 0, 8'h00, "R9");
    expect_at(0, 1, 8'h00, "R9");
    expect_at(0, 2, 8'h00, "R9");
    rd_chk(3'd1, 8'h00, "R9");
    rd_chk(3'd4, 8'h00, "R9");

    // R1 / R2: pull-up with all pins as inputs
    wr(3'd3, 8'hA5);
    expect_at(0, 2, 8'hA5, "R1");
    expect_at(0, 0, 8'h00, "R2");
    wr(3'd2, 8'h3C);
    expect_at(0, 1, 8'h3C, "R3");
    expect_at(0, 0, 8'h00, "R2");

    // R7 / R3: break-before-make off, outputs on in the update cycle
    wr(3'd1, 8'hF0);
    expect_at(0, 0, 8'hF0, "R7");
    expect_at(0, 1, 8'h3C, "R3");
    expect_at(0, 2, 8'hA5, "R1");

    // R4: toggle crosses input and output pins; zeros leave bits alone
    wr(3'd0, 8'h0F);
    expect_at(0, 1, 8'h33, "R4");
    wr(3'd0, 8'h00);
    expect_at(0, 1, 8'h33, "R4");

    // R11 readbacks
    rd_chk(3'd1, 8'hF0, "R11");
    rd_chk(3'd2, 8'h33, "R11");
    rd_chk(3'd3, 8'hA5, "R11");

    // R8: enable break-before-make
    wr(3'd4, 8'hFF);
    rd_chk(3'd4, 8'h01, "R8");

    // F0 -> 3C: 0C rise (gap), C0 fall (now), 30 stay
    wr(3'd1, 8'h3C);
    expect_at(0, 0, 8'h30, "R5");
    expect_at(1, 0, 8'h3C, "R5");
    step(); step();
    // 3C -> FF: C3 rise, 3C stay driving
    wr(3'd1, 8'hFF);
    expect_at(0, 0, 8'h3C, "R8");
    expect_at(1, 0, 8'hFF, "R8");
    step(); step();
    // FF -> 00 with break-before-make on
    wr(3'd1, 8'h00);
    expect_at(0, 0, 8'h00, "R6");
    step();

    // R10: synchronizer latency on the pin address
    addr = 3'd0;
    step(); step(); step();
    pad_in = 8'h5A;
    expect_at(2, 3, 8'h00, "R10");
    expect_at(3, 3, 8'h5A, "R10");
    repeat (5) step();

    // R9: asynchronous driver release, then clocked clear
    wr(3'd1, 8'hFF);
    step(); step();
    expect_at(0, 0, 8'hFF, "R5");
    step();
    rst = 1'b1;
    #0.5;
    n_chk++;
    if (pad_oe !== 8'h00) begin
      n_fail++;
      $display("FAIL R9 async oe actual=%02h expected=00", pad_oe);
    end
    step();
    rst = 1'b0;
    rd_chk(3'd1, 8'h00, "R9");
    rd_chk(3'd2, 8'h00, "R9");
    rd_chk(3'd4, 8'h00, "R9");
    expect_at(0, 0, 8'h00, "R9");
    repeat (3) step();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule